// File: doc/BRIEF.md
# Cross-Device Parity Reconstructor

This block produces and consumes the line-level correction word that sits beside a cache line stored across nine memory devices. A line is 513 bits, cut into nine 57-bit segments. Segment i occupies line bits [57i+56:57i], and segment i lives on device i. On a write, the block folds the nine segments together with XOR into one 57-bit parity. It then lays that parity out as a 72-bit correction word, with an 8-bit share per device. The word depends on the incoming line alone, so the memory never has to be read before a write.

On a read, a separate per-device detection tier has already judged each segment. It hands the block a 9-bit flag vector, where bit i set means segment i is bad. With no flags the line passes through untouched. With one flag the block rebuilds the bad segment from the eight good segments and the stored parity. With two or more flags the block reports failure and leaves the data as it arrived. The block also checks the correction word itself. If that word is damaged, the block refuses to use it for a rebuild.

Both paths are registered: results appear one clock after the request.

Top module: `xpar_recon`

## Requirements
- R1: The parity P is the bitwise XOR of the nine segments. For d in 0..7, the write word bits [8d+6:8d] hold P[7d+6:7d].
- R2: For d in 0..7, write word bit 8d+7 equals the XOR of that device's seven slice bits.
- R3: Write word bits [70:64] hold the XOR of the eight 7-bit slices. Write word bit 71 holds P[56].
- R4: A write request in one cycle sets wr_done and the word on cw_out in the next cycle. The word is a function of that request's line only, so back-to-back writes each give their own word.
- R5: A read with rd_flags all zero returns rd_line unchanged, with rd_corrected and rd_uncorrectable both low.
- R6: A read with exactly one flag and a self-consistent rd_cw returns the line with the flagged segment replaced by P XOR the other eight segments, where P is taken from rd_cw. rd_corrected is raised.
- R7: A read with two or more flags raises rd_uncorrectable, leaves rd_corrected low and returns rd_line unchanged.
- R8: rd_cw_bad is raised when any device's extra bit or the slice-XOR field of rd_cw disagrees with its slices. A read with one flag and a bad word is treated as uncorrectable, and the data is left unchanged.
- R9: A read request sets rd_done in the next cycle. In a cycle without a read result, rd_done, rd_corrected, rd_uncorrectable and rd_cw_bad are all low.
- R10: After reset, wr_done, rd_done, cw_out, rd_line_out and all status outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Encode request |
| wr_line | input | 513 | Line to encode |
| wr_done | output | 1 | Encode result valid |
| cw_out | output | 72 | Encoded correction word |
| rd_valid | input | 1 | Check/rebuild request |
| rd_line | input | 513 | Line as read from memory |
| rd_cw | input | 72 | Correction word as read from memory |
| rd_flags | input | 9 | Per-segment error flags from the detection tier |
| rd_done | output | 1 | Read result valid |
| rd_line_out | output | 513 | Returned (possibly rebuilt) line |
| rd_corrected | output | 1 | One segment was rebuilt |
| rd_uncorrectable | output | 1 | Line could not be repaired |
| rd_cw_bad | output | 1 | Correction word failed its own checks |

## Verification
Several properties are checked on every cycle:
- one-cycle latency of both paths;
- the corrected and uncorrectable indications never both being set;
- unchanged data on flag-free reads and on multi-flag reads;
- rebuilds only ever following a single flag with a clean word;
- the per-device extra bits and the slice-XOR field of every produced word being mutually consistent.

Other behaviour can only be shown by the bench's scenarios, which compare against an independent model. These include whether the parity bits are the right values in the right positions, whether a rebuilt segment actually equals the original, and how each kind of damage to the correction word is classified.

// File: rtl/xpar_pkg.sv
package xpar_pkg;
    // Default geometry: nine devices, 57-bit segments, 7-bit parity slices.
    localparam int unsigned SEG_W_DEF   = 57;
    localparam int unsigned N_SEG_DEF   = 9;
    localparam int unsigned SLICE_W_DEF = 7;

    typedef enum logic [1:0] {
        OUT_CLEAN = 2'd0,
        OUT_FIXED = 2'd1,
        OUT_FAIL  = 2'd2
    } rd_outcome_e;
endpackage

// File: rtl/xpar_encode.sv
// Folds the segments into the parity and lays it out as the correction word.
// Geometry must satisfy SEG_W == (N_SEG-1)*SLICE_W + 1.
module xpar_encode #(
    parameter int unsigned SEG_W   = xpar_pkg::SEG_W_DEF,
    parameter int unsigned N_SEG   = xpar_pkg::N_SEG_DEF,
    parameter int unsigned SLICE_W = xpar_pkg::SLICE_W_DEF,
    localparam int unsigned N_SL    = N_SEG - 1,
    localparam int unsigned SHARE_W = SLICE_W + 1,
    localparam int unsigned LINE_W  = N_SEG * SEG_W,
    localparam int unsigned CW_W    = N_SEG * SHARE_W
) (
    input  logic [LINE_W-1:0] line,
    output logic [SEG_W-1:0]  parity,
    output logic [CW_W-1:0]   cw
);
    logic [SLICE_W-1:0] pop;

    always_comb begin
        parity = '0;
        for (int s = 0; s < int'(N_SEG); s++) begin
            parity = parity ^ line[s*SEG_W +: SEG_W];
        end
    end

    always_comb begin
        pop = '0;
        for (int d = 0; d < int'(N_SL); d++) begin
            pop = pop ^ parity[d*SLICE_W +: SLICE_W];
        end
    end

    for (genvar d = 0; d < N_SL; d++) begin : g_share
        assign cw[d*SHARE_W +: SLICE_W] = parity[d*SLICE_W +: SLICE_W];
        assign cw[d*SHARE_W + SLICE_W]  = ^parity[d*SLICE_W +: SLICE_W];
    end

    assign cw[N_SL*SHARE_W +: SLICE_W] = pop;
    assign cw[CW_W-1]                  = parity[SEG_W-1];
endmodule

// File: rtl/xpar_unpack.sv
// Recovers the stored parity from a correction word and checks the word.
module xpar_unpack #(
    parameter int unsigned SEG_W   = xpar_pkg::SEG_W_DEF,
    parameter int unsigned N_SEG   = xpar_pkg::N_SEG_DEF,
    parameter int unsigned SLICE_W = xpar_pkg::SLICE_W_DEF,
    localparam int unsigned N_SL    = N_SEG - 1,
    localparam int unsigned SHARE_W = SLICE_W + 1,
    localparam int unsigned CW_W    = N_SEG * SHARE_W
) (
    input  logic [CW_W-1:0]  cw,
    output logic [SEG_W-1:0] parity,
    output logic             cw_bad
);
    logic [N_SL-1:0]    share_mis;
    logic [SLICE_W-1:0] pop_calc;

    for (genvar d = 0; d < N_SL; d++) begin : g_slice
        assign parity[d*SLICE_W +: SLICE_W] = cw[d*SHARE_W +: SLICE_W];
        assign share_mis[d] = cw[d*SHARE_W + SLICE_W] ^ (^cw[d*SHARE_W +: SLICE_W]);
    end

    assign parity[SEG_W-1] = cw[CW_W-1];

    always_comb begin
        pop_calc = '0;
        for (int d = 0; d < int'(N_SL); d++) begin
            pop_calc = pop_calc ^ cw[d*SHARE_W +: SLICE_W];
        end
    end

    assign cw_bad = (|share_mis) | (pop_calc != cw[N_SL*SHARE_W +: SLICE_W]);
endmodule

// File: rtl/xpar_rebuild.sv
// Replaces every flagged segment with itself XOR the syndrome when enabled.
module xpar_rebuild #(
    parameter int unsigned SEG_W = xpar_pkg::SEG_W_DEF,
    parameter int unsigned N_SEG = xpar_pkg::N_SEG_DEF,
    localparam int unsigned LINE_W = N_SEG * SEG_W
) (
    input  logic [LINE_W-1:0] line,
    input  logic [SEG_W-1:0]  parity,
    input  logic [N_SEG-1:0]  flags,
    input  logic              fix_en,
    output logic [LINE_W-1:0] line_out
);
    logic [SEG_W-1:0] syndrome;

    always_comb begin
        syndrome = parity;
        for (int s = 0; s < int'(N_SEG); s++) begin
            syndrome = syndrome ^ line[s*SEG_W +: SEG_W];
        end
    end

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        assign line_out[s*SEG_W +: SEG_W] = (fix_en && flags[s])
            ? (line[s*SEG_W +: SEG_W] ^ syndrome)
            : line[s*SEG_W +: SEG_W];
    end
endmodule

// File: rtl/xpar_recon.sv
module xpar_recon #(
    parameter int unsigned SEG_W   = xpar_pkg::SEG_W_DEF,
    parameter int unsigned N_SEG   = xpar_pkg::N_SEG_DEF,
    parameter int unsigned SLICE_W = xpar_pkg::SLICE_W_DEF,
    localparam int unsigned SHARE_W = SLICE_W + 1,
    localparam int unsigned LINE_W  = N_SEG * SEG_W,
    localparam int unsigned CW_W    = N_SEG * SHARE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [LINE_W-1:0] wr_line,
    output logic              wr_done,
    output logic [CW_W-1:0]   cw_out,
    input  logic              rd_valid,
    input  logic [LINE_W-1:0] rd_line,
    input  logic [CW_W-1:0]   rd_cw,
    input  logic [N_SEG-1:0]  rd_flags,
    output logic              rd_done,
    output logic [LINE_W-1:0] rd_line_out,
    output logic              rd_corrected,
    output logic              rd_uncorrectable,
    output logic              rd_cw_bad
);
    import xpar_pkg::*;

    typedef struct packed {
        logic              wr_done;
        logic [CW_W-1:0]   cw;
        logic              rd_done;
        logic [LINE_W-1:0] line;
        logic              corr;
        logic              unc;
        logic              bad;
    } state_t;

    state_t st_d, st_q;

    logic [SEG_W-1:0]  enc_parity;
    logic [CW_W-1:0]   enc_cw;
    logic [SEG_W-1:0]  rd_parity;
    logic              cw_bad;
    logic              flags_any, flags_multi;
    rd_outcome_e       outcome;
    logic [LINE_W-1:0] fixed_line;

    xpar_encode #(.SEG_W(SEG_W), .N_SEG(N_SEG), .SLICE_W(SLICE_W)) u_encode (
        .line   (wr_line),
        .parity (enc_parity),
        .cw     (enc_cw)
    );

    xpar_unpack #(.SEG_W(SEG_W), .N_SEG(N_SEG), .SLICE_W(SLICE_W)) u_unpack (
        .cw     (rd_cw),
        .parity (rd_parity),
        .cw_bad (cw_bad)
    );

    // Flag population: none, exactly one, or several.
    assign flags_any   = |rd_flags;
    assign flags_multi = |(rd_flags & (rd_flags - N_SEG'(1)));

    always_comb begin
        if (!flags_any)                outcome = OUT_CLEAN;
        else if (flags_multi || cw_bad) outcome = OUT_FAIL;
        else                           outcome = OUT_FIXED;
    end

    xpar_rebuild #(.SEG_W(SEG_W), .N_SEG(N_SEG)) u_rebuild (
        .line     (rd_line),
        .parity   (rd_parity),
        .flags    (rd_flags),
        .fix_en   (outcome == OUT_FIXED),
        .line_out (fixed_line)
    );

    always_comb begin
        st_d         = st_q;
        st_d.wr_done = wr_valid;
        if (wr_valid) begin
            st_d.cw = enc_cw;
        end
        st_d.rd_done = rd_valid;
        st_d.corr    = 1'b0;
        st_d.unc     = 1'b0;
        st_d.bad     = 1'b0;
        if (rd_valid) begin
            st_d.line = fixed_line;
            st_d.bad  = cw_bad;
            st_d.corr = (outcome == OUT_FIXED);
            st_d.unc  = (outcome == OUT_FAIL);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_done          = st_q.wr_done;
    assign cw_out           = st_q.cw;
    assign rd_done          = st_q.rd_done;
    assign rd_line_out      = st_q.line;
    assign rd_corrected     = st_q.corr;
    assign rd_uncorrectable = st_q.unc;
    assign rd_cw_bad        = st_q.bad;
endmodule

// File: rtl/xpar_recon_props.sv
module xpar_recon_props #(
    parameter int unsigned SEG_W   = xpar_pkg::SEG_W_DEF,
    parameter int unsigned N_SEG   = xpar_pkg::N_SEG_DEF,
    parameter int unsigned SLICE_W = xpar_pkg::SLICE_W_DEF,
    localparam int unsigned N_SL    = N_SEG - 1,
    localparam int unsigned SHARE_W = SLICE_W + 1,
    localparam int unsigned LINE_W  = N_SEG * SEG_W,
    localparam int unsigned CW_W    = N_SEG * SHARE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_done,
    input logic [CW_W-1:0]   cw_out,
    input logic              rd_valid,
    input logic [LINE_W-1:0] rd_line,
    input logic [N_SEG-1:0]  rd_flags,
    input logic              rd_done,
    input logic [LINE_W-1:0] rd_line_out,
    input logic              rd_corrected,
    input logic              rd_uncorrectable,
    input logic              rd_cw_bad
);
    logic               shares_ok;
    logic [SLICE_W-1:0] pop_seen;

    always_comb begin
        shares_ok = 1'b1;
        pop_seen  = '0;
        for (int d = 0; d < int'(N_SL); d++) begin
            if (cw_out[d*SHARE_W + SLICE_W] != ^cw_out[d*SHARE_W +: SLICE_W]) shares_ok = 1'b0;
            pop_seen = pop_seen ^ cw_out[d*SHARE_W +: SLICE_W];
        end
    end

    // R4
    wr_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> wr_done);

    // R2
    share_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> shares_ok);

    // R3
    pop_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> (cw_out[N_SL*SHARE_W +: SLICE_W] == pop_seen));

    // R9
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_done);

    // R9
    idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |-> !(rd_corrected || rd_uncorrectable || rd_cw_bad));

    // R5
    clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_flags == '0) |=>
            (!rd_corrected && !rd_uncorrectable && rd_line_out == $past(rd_line)));

    // R7
    multi_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $countones(rd_flags) > 1) |=>
            (rd_uncorrectable && !rd_corrected && rd_line_out == $past(rd_line)));

    // R6
    fix_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_corrected |-> ($countones($past(rd_flags)) == 1 && !rd_cw_bad && !rd_uncorrectable));

    // R8
    bad_word_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_cw_bad && $countones($past(rd_flags)) == 1) |->
            (rd_uncorrectable && rd_line_out == $past(rd_line)));
endmodule

bind xpar_recon xpar_recon_props #(.SEG_W(SEG_W), .N_SEG(N_SEG), .SLICE_W(SLICE_W)) u_props (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_valid         (wr_valid),
    .wr_done          (wr_done),
    .cw_out           (cw_out),
    .rd_valid         (rd_valid),
    .rd_line          (rd_line),
    .rd_flags         (rd_flags),
    .rd_done          (rd_done),
    .rd_line_out      (rd_line_out),
    .rd_corrected     (rd_corrected),
    .rd_uncorrectable (rd_uncorrectable),
    .rd_cw_bad        (rd_cw_bad)
);

// File: tb/xpar_recon_bench.sv
`timescale 1ns/1ps
module xpar_recon_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic [512:0] wr_line = '0;
    logic         wr_done;
    logic [71:0]  cw_out;
    logic         rd_valid = 1'b0;
    logic [512:0] rd_line = '0;
    logic [71:0]  rd_cw = '0;
    logic [8:0]   rd_flags = '0;
    logic         rd_done;
    logic [512:0] rd_line_out;
    logic         rd_corrected, rd_uncorrectable, rd_cw_bad;

    int n_checks = 0;
    int n_fails  = 0;

    // Scoreboard queues
    logic [71:0]  exp_cw_q[$];
    string        exp_wtag_q[$];
    logic [512:0] exp_line_q[$];
    logic [2:0]   exp_stat_q[$];   // {corr, unc, bad}
    string        exp_rtag_q[$];

    always #2.5 clk = ~clk;

    xpar_recon u_xpar_recon (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_line(wr_line), .wr_done(wr_done), .cw_out(cw_out),
        .rd_valid(rd_valid), .rd_line(rd_line), .rd_cw(rd_cw), .rd_flags(rd_flags),
        .rd_done(rd_done), .rd_line_out(rd_line_out), .rd_corrected(rd_corrected),
        .rd_uncorrectable(rd_uncorrectable), .rd_cw_bad(rd_cw_bad)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [575:0] act, input logic [575:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Independent model of the correction word from the requirements.
    function automatic logic [71:0] model_cw(input logic [512:0] l);
        logic [56:0] p = '0;
        logic [71:0] w = '0;
        for (int s = 0; s < 9; s++) p = p ^ l[s*57 +: 57];
        for (int d = 0; d < 8; d++) begin
            for (int b = 0; b < 7; b++) begin
                w[d*8 + b]  = p[d*7 + b];
                w[64 + b]   = w[64 + b] ^ p[d*7 + b];
            end
            w[d*8 + 7] = ^p[d*7 +: 7];
        end
        w[71] = p[56];
        return w;
    endfunction

    function automatic logic [512:0] rand_line();
        logic [512:0] r;
        for (int k = 0; k < 513; k++) r[k] = 1'($urandom);
        return r;
    endfunction

    function automatic logic [512:0] seg_damage(input int seg);
        logic [512:0] m = '0;
        logic [56:0]  v;
        for (int k = 0; k < 57; k++) v[k] = 1'($urandom);
        v[seg % 57] = 1'b1;
        m[seg*57 +: 57] = v;
        return m;
    endfunction

    task automatic wr_op(input logic [512:0] l, input string tag);
        @(negedge clk);
        rd_valid = 1'b0;
        wr_valid = 1'b1;
        wr_line  = l;
        exp_cw_q.push_back(model_cw(l));
        exp_wtag_q.push_back(tag);
    endtask

    task automatic rd_op(input logic [512:0] l, input logic [71:0] w, input logic [8:0] f,
                         input logic [512:0] el, input logic [2:0] es, input string tag);
        @(negedge clk);
        wr_valid = 1'b0;
        rd_valid = 1'b1;
        rd_line  = l;
        rd_cw    = w;
        rd_flags = f;
        exp_line_q.push_back(el);
        exp_stat_q.push_back(es);
        exp_rtag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_valid = 1'b0;
        rd_valid = 1'b0;
        rd_flags = '0;
    endtask

    // Monitor: compare results as they appear.
    always @(negedge clk) begin
        if (rst_n && wr_done) begin
            if (exp_cw_q.size() == 0) begin
                check(1'b0, "R4", "unexpected wr_done", 576'(1), 576'(0));
            end else begin
                logic [71:0] e;
                string t;
                e = exp_cw_q.pop_front();
                t = exp_wtag_q.pop_front();
                check(cw_out === e, t, "correction word", 576'(cw_out), 576'(e));
            end
        end
        if (rst_n && rd_done) begin
            if (exp_line_q.size() == 0) begin
                check(1'b0, "R9", "unexpected rd_done", 576'(1), 576'(0));
            end else begin
                logic [512:0] el;
                logic [2:0]   es;
                string        t;
                el = exp_line_q.pop_front();
                es = exp_stat_q.pop_front();
                t  = exp_rtag_q.pop_front();
                check(rd_line_out === el, t, "line", 576'(rd_line_out), 576'(el));
                check({rd_corrected, rd_uncorrectable, rd_cw_bad} === es, t, "status {corr,unc,bad}",
                      576'({rd_corrected, rd_uncorrectable, rd_cw_bad}), 576'(es));
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [512:0] base, dmg, l2;
        logic [71:0]  w;
        logic [512:0] ones;
        ones = '1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check({wr_done, rd_done, rd_corrected, rd_uncorrectable, rd_cw_bad} === 5'b0, "R10",
              "status after reset", 576'({wr_done, rd_done, rd_corrected, rd_uncorrectable, rd_cw_bad}), 576'(0));
        check(cw_out === '0 && rd_line_out === '0, "R10", "data after reset",
              576'(cw_out), 576'(0));
        rst_n = 1'b1;

        // Writes
        wr_op('0, "R1");
        wr_op(ones, "R1");                        // all-ones parity
        l2 = '0; l2[3*57 + 56] = 1'b1;
        wr_op(l2, "R3");                          // only bit 71 set
        l2 = '0; l2[5*57 + 9] = 1'b1;
        wr_op(l2, "R2");                          // slice 1 bit 2 + its extra bit + pop bit
        for (int i = 0; i < 6; i++) wr_op(rand_line(), "R4");
        idle();
        idle();
        check(wr_done === 1'b0, "R4", "wr_done low when idle", 576'(wr_done), 576'(0));

        // Explicit field positions for the single-bit line above (bit 9 of seg 5 -> P[9])
        base = '0; base[5*57 + 9] = 1'b1;
        w = model_cw(base);
        check(w === (72'(1) << 10 | 72'(1) << 15 | 72'(1) << 66), "R2",
              "model field positions", 576'(w), 576'(72'(1) << 10 | 72'(1) << 15 | 72'(1) << 66));

        // Reads
        base = rand_line();
        w = model_cw(base);
        rd_op(base, w, 9'h000, base, 3'b000, "R5");
        dmg = base ^ seg_damage(4);
        rd_op(dmg, w, 9'h000, dmg, 3'b000, "R5");      // no flags: damage passes through
        for (int s = 0; s < 9; s++) begin
            dmg = base ^ seg_damage(s);
            rd_op(dmg, w, 9'(1) << s, base, 3'b100, "R6");
        end
        dmg = base ^ seg_damage(2) ^ seg_damage(7);
        rd_op(dmg, w, 9'h084, dmg, 3'b010, "R7");
        rd_op(dmg, w, 9'h1FF, dmg, 3'b010, "R7");
        dmg = base ^ seg_damage(0);
        rd_op(dmg, w ^ 72'(1) << 3, 9'h001, dmg, 3'b011, "R8");   // slice bit flipped
        rd_op(dmg, w ^ 72'(1) << 23, 9'h001, dmg, 3'b011, "R8");  // extra bit flipped
        rd_op(base, w ^ 72'(1) << 65, 9'h000, base, 3'b001, "R8"); // pop bit flipped, clean read
        rd_op(rand_line() & '0, model_cw('0), 9'h100, '0, 3'b100, "R6"); // zero line, fix no-op
        idle();
        idle();
        check({rd_done, rd_corrected, rd_uncorrectable, rd_cw_bad} === 4'b0, "R9",
              "read status low when idle", 576'({rd_done, rd_corrected, rd_uncorrectable, rd_cw_bad}), 576'(0));
        check(exp_cw_q.size() == 0 && exp_line_q.size() == 0, "R9", "all results delivered",
              576'(exp_cw_q.size() + exp_line_q.size()), 576'(0));
        finish_run();
    end
endmodule